// File: doc/BRIEF.md
# Binary Buddy Page Allocator

This block hands out and takes back aligned blocks of pages from a pool of 2^POOL_LOG2 pages. An allocation request carries a page count. The block rounds the count up to a power of two and returns the base page index of a free, naturally aligned block of that size. A free request carries a base index and an order, where order k means 2^k pages. The block keeps one free bit per block per order. It cuts larger blocks in half when an allocation needs a smaller block. When a block is released, it joins the block with its free neighbour of the same size.

One request is taken at a time. A request is accepted in any cycle where `req_valid` is high and `busy` is low. The block then walks through its state machine one step per clock. It ends with a single-cycle response that carries a fail flag and a base index.

The state machine has five states:
- ST_IDLE waits for a request. Acceptance moves it to ST_SEARCH.
- ST_SEARCH checks the request.
  - A rejected request goes to ST_RESP.
  - An allocation that finds a free block of exactly the right size goes to ST_RESP.
  - An allocation that finds a larger block goes to ST_SPLIT.
  - A valid free goes to ST_MERGE.
- ST_SPLIT halves the held block once per cycle. It goes to ST_RESP when the target order is reached.
- ST_MERGE joins the held block with its buddy once per cycle while the buddy is free. When it can join no further, it records the result as free and goes to ST_RESP.
- ST_RESP raises the response for one cycle and returns to ST_IDLE.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, `busy` and `rsp_valid` are low and the whole pool is one free block of order POOL_LOG2, so an allocation of 2^POOL_LOG2 pages succeeds with base 0.
- R2: An allocation of p pages uses target order t, the smallest t with 2^t >= p. A count of 0 is treated as 1 page. The returned base is a multiple of 2^t.
- R3: An allocation takes a block from the lowest order j >= t that has a free block, and at that order the block with the lowest base.
- R4: When j > t, the block is halved once per cycle. The lower half is kept each time and each upper half is marked free. `busy` is high for 2 + (j - t) cycles, counted from the cycle after acceptance.
- R5: An allocation of more than 2^POOL_LOG2 pages responds with `rsp_fail` high two cycles after acceptance (busy for 2 cycles) and changes no state.
- R6: An allocation made when no free block of order >= t exists responds with `rsp_fail` high, busy for 2 cycles, and changes no state.
- R7: A valid free of block (B, k) repeatedly joins the held block with its buddy at base B XOR 2^k while that buddy is free and k < POOL_LOG2. Each join takes one cycle, and the joined block has base B with bit k cleared. `busy` lasts 3 + m cycles for m joins. `rsp_base` gives the base of the resulting free block.
- R8: A free whose order exceeds POOL_LOG2, whose base is not a multiple of 2^order, or whose block is not currently allocated at that order responds with `rsp_fail` high, busy for 2 cycles, and leaves all state unchanged.
- R9: A request is accepted only when `busy` is low. `busy` rises in the cycle after acceptance and stays high through the response. `rsp_valid` is high for exactly one cycle, the last busy cycle. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_free | input | 1 | 0 = allocate, 1 = free |
| req_pages | input | POOL_LOG2+2 | Page count for an allocation |
| req_base | input | POOL_LOG2 | Base page index for a free |
| req_order | input | clog2(POOL_LOG2+1) | Block order for a free |
| busy | output | 1 | Operation in progress; requests are ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fail | output | 1 | Request rejected (qualified by rsp_valid) |
| rsp_base | output | POOL_LOG2 | Allocated base, or base of the merged free block |

## Verification
The checker watches the handshake on every cycle:
- `busy` rises after acceptance.
- The response is a one-cycle pulse inside the busy window, and `busy` drops right after it.
- The fail flag only appears with a response.
- Oversize allocations and out-of-range free orders are rejected exactly two cycles after acceptance.

Which block is chosen, how long the split and merge chains run, and whether rejected requests truly leave the pool untouched depend on the history of the pool. Only the bench's scenarios can show these. Its behavioural model tracks every free and allocated block and predicts `busy`, `rsp_valid`, `rsp_fail` and `rsp_base` for each cycle.

// File: rtl/buddy_alloc_pkg.sv
package buddy_alloc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_SPLIT,
        ST_MERGE,
        ST_RESP
    } state_e;

    // Flat bit position of block (order k, base b) in an n-level map.
    // Orders are stacked from order 0 upward; order k holds 2^(n-k) bits.
    function automatic int map_pos(input int n, input int k, input int b);
        return (1 << (n + 1)) - (1 << (n - k + 1)) + (b >> k);
    endfunction

endpackage

// File: rtl/buddy_order_calc.sv
module buddy_order_calc #(
    parameter int N  = 4,
    parameter int PW = N + 2,
    parameter int OW = $clog2(N + 1)
) (
    input  logic [PW-1:0] pages,
    output logic [OW-1:0] order,
    output logic          too_big
);

    always_comb begin
        too_big = (pages > PW'(1 << N));
        order   = '0;
        // Descending scan: the last match is the smallest fitting order.
        for (int t = N; t >= 0; t--) begin
            if (pages <= PW'(1 << t)) begin
                order = OW'(t);
            end
        end
    end

endmodule

// File: rtl/buddy_block_search.sv
module buddy_block_search #(
    parameter int N   = 4,
    parameter int OW  = $clog2(N + 1),
    parameter int TOT = (1 << (N + 1)) - 1
) (
    input  logic [TOT-1:0] free_map,
    input  logic [OW-1:0]  min_order,
    output logic           found,
    output logic [OW-1:0]  hit_order,
    output logic [N-1:0]   hit_base
);

    logic [N:0]        lvl_hit;
    logic [N:0][N-1:0] lvl_idx;

    // One lowest-index finder per order level.
    for (genvar gk = 0; gk <= N; gk++) begin : g_level
        localparam int CNT = 1 << (N - gk);
        localparam int OFF = (1 << (N + 1)) - (1 << (N - gk + 1));
        logic         h;
        logic [N-1:0] ix;
        always_comb begin
            h  = 1'b0;
            ix = '0;
            for (int i = CNT - 1; i >= 0; i--) begin
                if (free_map[OFF + i]) begin
                    h  = 1'b1;
                    ix = N'(i);
                end
            end
        end
        assign lvl_hit[gk] = h;
        assign lvl_idx[gk] = ix;
    end

    always_comb begin
        found     = 1'b0;
        hit_order = '0;
        hit_base  = '0;
        for (int k = N; k >= 0; k--) begin
            if (lvl_hit[k] && (OW'(k) >= min_order)) begin
                found     = 1'b1;
                hit_order = OW'(k);
                hit_base  = N'(lvl_idx[k] << k);
            end
        end
    end

endmodule

// File: rtl/buddy_alloc.sv
module buddy_alloc
    import buddy_alloc_pkg::*;
#(
    parameter int POOL_LOG2 = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic                             req_free,
    input  logic [POOL_LOG2+1:0]             req_pages,
    input  logic [POOL_LOG2-1:0]             req_base,
    input  logic [$clog2(POOL_LOG2+1)-1:0]   req_order,
    output logic                             busy,
    output logic                             rsp_valid,
    output logic                             rsp_fail,
    output logic [POOL_LOG2-1:0]             rsp_base
);

    localparam int N   = POOL_LOG2;
    localparam int PW  = N + 2;
    localparam int OW  = $clog2(N + 1);
    localparam int TOT = (1 << (N + 1)) - 1;

    state_e         state_q, state_d;
    logic [TOT-1:0] free_q, alloc_q;
    logic           op_free_q, fail_q;
    logic [PW-1:0]  pages_q;
    logic [N-1:0]   base_q, cur_base_q;
    logic [OW-1:0]  order_q, cur_order_q;

    logic [OW-1:0]  tgt_order;
    logic           too_big;
    logic           found;
    logic [OW-1:0]  hit_order;
    logic [N-1:0]   hit_base;

    buddy_order_calc #(.N(N), .PW(PW), .OW(OW)) u_order (
        .pages   (pages_q),
        .order   (tgt_order),
        .too_big (too_big)
    );

    buddy_block_search #(.N(N), .OW(OW), .TOT(TOT)) u_search (
        .free_map  (free_q),
        .min_order (tgt_order),
        .found     (found),
        .hit_order (hit_order),
        .hit_base  (hit_base)
    );

    // Decision terms shared by the next-state and datapath processes.
    logic          alloc_ok, free_ok, merge_go;
    logic [OW-1:0] split_order;
    logic [N-1:0]  split_upper, buddy_base;

    always_comb begin
        alloc_ok    = !too_big && found;
        free_ok     = 1'b0;
        if (int'(order_q) <= N) begin
            free_ok = ((int'(base_q) & ((1 << int'(order_q)) - 1)) == 0) &&
                      alloc_q[map_pos(N, int'(order_q), int'(base_q))];
        end
        split_order = cur_order_q - 1'b1;
        split_upper = cur_base_q | N'(1 << int'(split_order));
        buddy_base  = '0;
        merge_go    = 1'b0;
        if (int'(cur_order_q) < N) begin
            buddy_base = cur_base_q ^ N'(1 << int'(cur_order_q));
            merge_go   = free_q[map_pos(N, int'(cur_order_q), int'(buddy_base))];
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_SEARCH;
            ST_SEARCH: begin
                if (op_free_q)
                    state_d = free_ok ? ST_MERGE : ST_RESP;
                else if (alloc_ok && hit_order != tgt_order)
                    state_d = ST_SPLIT;
                else
                    state_d = ST_RESP;
            end
            ST_SPLIT:  if (split_order == tgt_order) state_d = ST_RESP;
            ST_MERGE:  if (!merge_go) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_q            <= '0;
            free_q[TOT-1]     <= 1'b1;
            alloc_q           <= '0;
            op_free_q         <= 1'b0;
            fail_q            <= 1'b0;
            pages_q           <= '0;
            base_q            <= '0;
            order_q           <= '0;
            cur_base_q        <= '0;
            cur_order_q       <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_free_q <= req_free;
                        pages_q   <= req_pages;
                        base_q    <= req_base;
                        order_q   <= req_order;
                    end
                end
                ST_SEARCH: begin
                    if (op_free_q) begin
                        fail_q <= !free_ok;
                        if (free_ok) begin
                            alloc_q[map_pos(N, int'(order_q), int'(base_q))] <= 1'b0;
                            cur_base_q  <= base_q;
                            cur_order_q <= order_q;
                        end else begin
                            cur_base_q  <= '0;
                        end
                    end else begin
                        fail_q <= !alloc_ok;
                        if (alloc_ok) begin
                            free_q[map_pos(N, int'(hit_order), int'(hit_base))] <= 1'b0;
                            if (hit_order == tgt_order)
                                alloc_q[map_pos(N, int'(tgt_order), int'(hit_base))] <= 1'b1;
                            cur_base_q  <= hit_base;
                            cur_order_q <= hit_order;
                        end else begin
                            cur_base_q  <= '0;
                        end
                    end
                end
                ST_SPLIT: begin
                    free_q[map_pos(N, int'(split_order), int'(split_upper))] <= 1'b1;
                    cur_order_q <= split_order;
                    if (split_order == tgt_order)
                        alloc_q[map_pos(N, int'(split_order), int'(cur_base_q))] <= 1'b1;
                end
                ST_MERGE: begin
                    if (merge_go) begin
                        free_q[map_pos(N, int'(cur_order_q), int'(buddy_base))] <= 1'b0;
                        cur_base_q  <= cur_base_q & ~N'(1 << int'(cur_order_q));
                        cur_order_q <= cur_order_q + 1'b1;
                    end else begin
                        free_q[map_pos(N, int'(cur_order_q), int'(cur_base_q))] <= 1'b1;
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_fail  = rsp_valid && fail_q;
        rsp_base  = rsp_valid ? cur_base_q : '0;
    end

endmodule

// File: rtl/buddy_alloc_chk.sv
module buddy_alloc_chk #(
    parameter int POOL_LOG2 = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_free,
    input logic [POOL_LOG2+1:0]           req_pages,
    input logic [$clog2(POOL_LOG2+1)-1:0] req_order,
    input logic                           busy,
    input logic                           rsp_valid,
    input logic                           rsp_fail
);

    localparam int POOL = 1 << POOL_LOG2;

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_resp_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    assert_resp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    assert_fail_with_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fail |-> rsp_valid);

    assert_oversize_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_free && (int'(req_pages) > POOL))
        |=> ##1 (rsp_valid && rsp_fail));

    assert_bad_order_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_free && (int'(req_order) > POOL_LOG2))
        |=> ##1 (rsp_valid && rsp_fail));

endmodule

bind buddy_alloc buddy_alloc_chk #(.POOL_LOG2(POOL_LOG2)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_free  (req_free),
    .req_pages (req_pages),
    .req_order (req_order),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_fail  (rsp_fail)
);

// File: tb/buddy_alloc_bench.sv
module buddy_alloc_bench;

    localparam int N    = 4;
    localparam int POOL = 1 << N;
    localparam int OW   = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_free = 1'b0;
    logic [N+1:0]      req_pages = '0;
    logic [N-1:0]      req_base = '0;
    logic [OW-1:0]     req_order = '0;
    logic              busy, rsp_valid, rsp_fail;
    logic [N-1:0]      rsp_base;

    always #5 clk = ~clk;

    buddy_alloc #(.POOL_LOG2(N)) u_buddy_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_free(req_free),
        .req_pages(req_pages), .req_base(req_base), .req_order(req_order),
        .busy(busy), .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_base(rsp_base)
    );

    int total = 0;
    int failed = 0;
    bit finished = 0;

    // Reference pool state: fm = free blocks, am = allocated blocks, per order and index.
    bit fm [0:N][0:POOL-1];
    bit am [0:N][0:POOL-1];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k <= N; k++)
            for (int i = 0; i < POOL; i++) begin
                fm[k][i] = 0;
                am[k][i] = 0;
            end
        fm[N][0] = 1;
    endtask

    // Run one request through the model, drive it, and compare every cycle.
    task automatic do_req(input bit fr, input int pages, input int base, input int order,
                          input bit hold, input string tag);
        int  lat, eb, t, j, idx, k, b, m;
        bit  ef;
        ef = 1; eb = 0; lat = 2;
        if (!fr) begin
            t = 0;
            while ((1 << t) < pages) t++;
            j = -1; idx = 0;
            if (pages <= POOL) begin
                for (int kk = N; kk >= t; kk--)
                    for (int ii = POOL - 1; ii >= 0; ii--)
                        if (ii < (POOL >> kk) && fm[kk][ii]) begin j = kk; idx = ii; end
            end
            if (j >= 0) begin
                ef = 0;
                eb = idx << j;
                fm[j][idx] = 0;
                for (int kk = j - 1; kk >= t; kk--) fm[kk][(eb >> kk) + 1] = 1;
                am[t][eb >> t] = 1;
                lat = 2 + j - t;
            end
        end else begin
            if (order <= N && (base % (1 << order)) == 0 && am[order][base >> order]) begin
                ef = 0;
                am[order][base >> order] = 0;
                k = order; b = base; m = 0;
                while (k < N && fm[k][(b >> k) ^ 1]) begin
                    fm[k][(b >> k) ^ 1] = 0;
                    b = b & ~(1 << k);
                    k++; m++;
                end
                fm[k][b >> k] = 1;
                eb = b;
                lat = 3 + m;
            end
        end
        req_valid = 1; req_free = fr;
        req_pages = (N+2)'(pages); req_base = N'(base); req_order = OW'(order);
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            if (i == 1 && !hold) req_valid = 0;
            if (i == 2) req_valid = 0;
            check(busy === 1'b1, {tag, " busy window"}, int'(busy), 1);
            check(rsp_valid === (i == lat), "R9 response strobe", int'(rsp_valid), int'(i == lat));
            if (i == lat) begin
                check(rsp_fail === ef, {tag, " fail flag"}, int'(rsp_fail), int'(ef));
                if (!ef) check(int'(rsp_base) == eb, {tag, " base"}, int'(rsp_base), eb);
            end
        end
        @(negedge clk);
        check(busy === 1'b0 && rsp_valid === 1'b0, "R9 return to idle",
              int'({busy, rsp_valid}), 0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        check(rsp_valid === 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
        rst_n = 1;
        @(negedge clk);
        do_req(0, 16, 0, 0, 0, "R1");      // whole pool, no split
        do_req(1, 0, 0, 4, 0, "R7");       // free it back
        do_req(0, 3, 0, 0, 0, "R4");       // 16 -> 8 -> 4, base 0
        do_req(0, 1, 0, 0, 1, "R3");       // lowest order with free: order 2 at base 4; held while busy (R9)
        do_req(0, 0, 0, 0, 0, "R2");       // zero pages -> one page, base 5
        do_req(0, 17, 0, 0, 0, "R5");      // larger than pool
        do_req(0, 8, 0, 0, 0, "R3");       // order 3 block at base 8
        do_req(0, 4, 0, 0, 0, "R6");       // no order >= 2 left
        do_req(0, 2, 0, 0, 0, "R2");       // base 6
        do_req(0, 1, 0, 0, 0, "R6");       // pool full
        do_req(1, 0, 4, 1, 0, "R8");       // allocated at order 0, not 1
        do_req(1, 0, 2, 2, 0, "R8");       // misaligned
        do_req(1, 0, 0, 5, 0, "R8");       // order beyond pool
        do_req(0, 1, 0, 0, 0, "R8");       // still full: rejected frees changed nothing
        do_req(1, 0, 5, 0, 0, "R7");       // buddy 4 allocated: no merge
        do_req(1, 0, 4, 0, 0, "R7");       // merge to (4,1)
        do_req(1, 0, 6, 1, 0, "R7");       // merge to (4,2)
        do_req(1, 0, 0, 2, 0, "R7");       // merge to (0,3)
        do_req(1, 0, 8, 3, 0, "R7");       // merge to whole pool
        do_req(1, 0, 8, 3, 0, "R8");       // double free
        do_req(0, 16, 0, 0, 0, "R7");      // whole pool usable again
        do_req(0, 5, 0, 0, 0, "R6");       // nothing free after full allocation
        finished = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            failed++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule